// File: doc/BRIEF.md
# Card Receive FIFO with Clock-Crossing Write Handshake

This block buffers words that arrive from a card data path for a peripheral bus to collect. It holds 16 words of 32 bits. The writer runs on its own clock. It places a word on `wrData` and raises the `wrEn` level. The bus clock domain synchronizes that level and stores the word. It then advances its write pointer and raises an acknowledge. The acknowledge travels back to the writer domain as `wrDone`. The writer drops `wrEn` when it sees `wrDone`. The acknowledge falls once the dropped level has crossed over. The writer may start its next word only after `wrDone` has gone low again, which makes a four-phase handshake.

On the bus side, `rdData` always presents the word at the read pointer. A one-cycle `rdInc` strobe consumes that word. The block reports five status flags in the bus clock domain and an activity indication. `halfFull` is suitable as a transfer request. Clearing `fifoEnable` empties the buffer, resets both pointers and holds every flag low.

Top module: `card_rx_fifo`

## Requirements
- R1: A write is a four-phase handshake. `wrEn` passes through two bus-clock flops. The word is written to storage before the write pointer advances. `wrDone` (two writer-clock flops after the bus-side acknowledge) goes high and stays high until the dropped `wrEn` has been seen, then returns low.
- R2: `rdData` always shows the oldest unread word, so words leave in the order they were written, including across pointer wrap-around.
- R3: A one-cycle `rdInc` pulse while at least one word is held consumes exactly one word.
- R4: An `rdInc` pulse while the buffer is empty is ignored: the read pointer does not move, and the next word written is the next word read.
- R5: Capacity is 16 words; `fifoFull` is high exactly when 16 words are held.
- R6: While enabled, `fifoEmpty` is high when no word is held, and `dataAvail` is its inverse.
- R7: `halfFull` is high when 8 or more words are held and low at 7 or fewer.
- R8: A write that arrives while full is acknowledged normally but discarded, and it sets `overrun`. `overrun` stays set through reads until a one-cycle `ovrClear` pulse clears it. The stored words are not disturbed.
- R9: While `fifoEnable` is low, all five flags are low and the word count and both pointers are held at zero. Writes offered while disabled are acknowledged and discarded, so after re-enabling the buffer reads as empty.
- R10: `rxActive` is high while a write request is being served in the bus domain (from the synchronized `wrEn` until the acknowledge drops) and low when no write is in flight.
- R11: After reset with `fifoEnable` high, `fifoEmpty` is 1, the other flags are 0, and `wrDone` and `rxActive` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Peripheral bus clock |
| busRstN | input | 1 | Asynchronous active-low reset, bus domain |
| wrClk | input | 1 | Card data-path clock |
| wrRstN | input | 1 | Asynchronous active-low reset, writer domain |
| wrEn | input | 1 | Write request level from the writer |
| wrData | input | 32 | Word to store, held stable while `wrEn` is high |
| wrDone | output | 1 | Write acknowledge, writer domain |
| fifoEnable | input | 1 | Buffer enable; low empties and resets the buffer |
| rdInc | input | 1 | Consume-word strobe from the bus logic |
| ovrClear | input | 1 | Clears the overrun flag |
| rdData | output | 32 | Word at the read pointer |
| rxActive | output | 1 | A write request is being served |
| fifoFull | output | 1 | 16 words held |
| fifoEmpty | output | 1 | No word held (enabled only) |
| halfFull | output | 1 | 8 or more words held |
| dataAvail | output | 1 | At least one word held |
| overrun | output | 1 | Sticky: a write was discarded while full |

## Verification
The word count and the pointers are invisible except through the flags and `rdData`. A count that is off by one shows up on the next flag threshold the bench crosses, which is at most 8 writes away. A pointer that slips shows up as an out-of-order word on the very next read that the scoreboard compares. A handshake that stalls leaves `wrDone` stuck high or low, and the write task hangs within a few cycles. A pointer or count that survives disabling shows up as a non-empty flag, or as a stale word on the first read after re-enabling.

// File: rtl/card_rx_pkg.sv
package card_rx_pkg;

  // Strobes issued by the control block to the storage block
  typedef struct packed {
    logic store;   // write the presented word at the write pointer
    logic advWr;   // step the write pointer
    logic advRd;   // step the read pointer
    logic clrAll;  // force both pointers to zero
  } rxStrobes_t;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_STORE = 2'd1,
    HS_ADV   = 2'd2,
    HS_ACK   = 2'd3
  } hsState_t;

endpackage

// File: rtl/card_rx_sync.sv
module card_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else       shiftReg <= {shiftReg[STAGES-2:0], d};
  end

  assign q = shiftReg[STAGES-1];
endmodule

// File: rtl/card_rx_ctrl.sv
module card_rx_ctrl
  import card_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enSync,
  input  logic       fifoEnable,
  input  logic       rdInc,
  input  logic       ovrClear,
  output rxStrobes_t strobes,
  output logic       wrAck,
  output logic       rxActive,
  output logic       fifoFull,
  output logic       fifoEmpty,
  output logic       halfFull,
  output logic       dataAvail,
  output logic       overrun
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int HALF  = DEPTH / 2;

  hsState_t         state;
  logic [CNT_W-1:0] count;
  logic             ovrReg;
  logic             isFull;

  assign isFull = (count == CNT_W'(DEPTH));

  // Handshake sequencer: store, then advance, then acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= HS_IDLE;
      wrAck <= 1'b0;
    end else begin
      case (state)
        HS_IDLE: begin
          if (enSync) begin
            if (fifoEnable && !isFull) state <= HS_STORE;
            else begin
              state <= HS_ACK;
              wrAck <= 1'b1;
            end
          end
        end
        HS_STORE: state <= HS_ADV;
        HS_ADV: begin
          state <= HS_ACK;
          wrAck <= 1'b1;
        end
        HS_ACK: begin
          if (!enSync) begin
            state <= HS_IDLE;
            wrAck <= 1'b0;
          end
        end
        default: state <= HS_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.store  = (state == HS_STORE) && fifoEnable;
    strobes.advWr  = (state == HS_ADV) && fifoEnable;
    strobes.advRd  = rdInc && fifoEnable && (count != '0);
    strobes.clrAll = !fifoEnable;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            count <= '0;
    else if (!fifoEnable) count <= '0;
    else begin
      case ({strobes.advWr, strobes.advRd})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                       ovrReg <= 1'b0;
    else if (!fifoEnable)                            ovrReg <= 1'b0;
    else if (state == HS_IDLE && enSync && isFull)   ovrReg <= 1'b1;
    else if (ovrClear)                               ovrReg <= 1'b0;
  end

  assign rxActive  = enSync | wrAck;
  assign fifoFull  = fifoEnable && isFull;
  assign fifoEmpty = fifoEnable && (count == '0);
  assign dataAvail = fifoEnable && (count != '0);
  assign halfFull  = fifoEnable && (count >= CNT_W'(HALF));
  assign overrun   = fifoEnable && ovrReg;

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH))
    else $error("word count beyond capacity");

  // R4
  empty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEnable && count == '0 && rdInc && state != HS_ADV) |=> (count == '0))
    else $error("read while empty changed the count");

  // R1
  store_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advWr |-> ($past(state) == HS_STORE))
    else $error("pointer advance without a preceding store");

  // R1
  ack_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == HS_ACK && !enSync) |=> (!wrAck && state == HS_IDLE))
    else $error("acknowledge not released after request drop");

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovrReg && fifoEnable && !ovrClear) |=> ovrReg)
    else $error("overrun lost without a clear");

  // R7
  flag_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> (halfFull && dataAvail && !fifoEmpty))
    else $error("inconsistent flags while full");
endmodule

// File: rtl/card_rx_dpath.sv
module card_rx_dpath
  import card_rx_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxStrobes_t       strobes,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData
);
  localparam int ADDR_W = $clog2(DEPTH);

  logic [WIDTH-1:0]  mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] rdPtr;

  always_ff @(posedge clk) begin
    if (strobes.store) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strobes.clrAll) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.advWr) wrPtr <= wrPtr + ADDR_W'(1);
      if (strobes.advRd) rdPtr <= rdPtr + ADDR_W'(1);
    end
  end

  assign rdData = mem[rdPtr];

  // R9
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrAll |=> (wrPtr == '0 && rdPtr == '0))
    else $error("pointers not cleared while disabled");

  // R2
  wr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advWr && !strobes.clrAll) |=> (wrPtr == ADDR_W'($past(wrPtr) + ADDR_W'(1))))
    else $error("write pointer did not step by one");
endmodule

// File: rtl/card_rx_fifo.sv
module card_rx_fifo
  import card_rx_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16
) (
  input  logic             busClk,
  input  logic             busRstN,
  input  logic             wrClk,
  input  logic             wrRstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  output logic             wrDone,
  input  logic             fifoEnable,
  input  logic             rdInc,
  input  logic             ovrClear,
  output logic [WIDTH-1:0] rdData,
  output logic             rxActive,
  output logic             fifoFull,
  output logic             fifoEmpty,
  output logic             halfFull,
  output logic             dataAvail,
  output logic             overrun
);
  logic       enSync;
  logic       wrAck;
  rxStrobes_t strobes;

  card_rx_sync #(.STAGES(2)) u_enSync (
    .clk (busClk), .rstN(busRstN), .d(wrEn), .q(enSync)
  );

  card_rx_sync #(.STAGES(2)) u_ackSync (
    .clk (wrClk), .rstN(wrRstN), .d(wrAck), .q(wrDone)
  );

  card_rx_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (busClk),
    .rstN      (busRstN),
    .enSync    (enSync),
    .fifoEnable(fifoEnable),
    .rdInc     (rdInc),
    .ovrClear  (ovrClear),
    .strobes   (strobes),
    .wrAck     (wrAck),
    .rxActive  (rxActive),
    .fifoFull  (fifoFull),
    .fifoEmpty (fifoEmpty),
    .halfFull  (halfFull),
    .dataAvail (dataAvail),
    .overrun   (overrun)
  );

  card_rx_dpath #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dpath (
    .clk    (busClk),
    .rstN   (busRstN),
    .strobes(strobes),
    .wrData (wrData),
    .rdData (rdData)
  );
endmodule

// File: tb/card_rx_fifo_bench.sv
`timescale 1ns/1ps
module card_rx_fifo_bench;
  logic        busClk = 0, wrClk = 0;
  logic        busRstN = 0, wrRstN = 0;
  logic        wrEn = 0, fifoEnable = 1, rdInc = 0, ovrClear = 0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        wrDone, rxActive, fifoFull, fifoEmpty, halfFull, dataAvail, overrun;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] expQ[$];
  string readTag = "R2";

  always #2   busClk = ~busClk;   // 250 MHz
  always #3.5 wrClk  = ~wrClk;

  card_rx_fifo u_card_rx_fifo (
    .busClk(busClk), .busRstN(busRstN), .wrClk(wrClk), .wrRstN(wrRstN),
    .wrEn(wrEn), .wrData(wrData), .wrDone(wrDone), .fifoEnable(fifoEnable),
    .rdInc(rdInc), .ovrClear(ovrClear), .rdData(rdData), .rxActive(rxActive),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .halfFull(halfFull),
    .dataAvail(dataAvail), .overrun(overrun)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // flag order: {full, empty, half, avail, overrun}
  task automatic checkFlags(input string tag, input logic [4:0] exp);
    @(negedge busClk);
    check(tag, {27'd0, fifoFull, fifoEmpty, halfFull, dataAvail, overrun}, {27'd0, exp});
  endtask

  // Driver: four-phase write; pushes the word when it is expected to be kept
  task automatic writeWord(input logic [31:0] d, input bit keep, input bit probeActive);
    @(posedge wrClk); #1;
    wrData = d;
    wrEn   = 1'b1;
    @(negedge wrClk);
    while (!wrDone) @(negedge wrClk);
    if (probeActive) check("R10 active during write", {31'd0, rxActive}, 32'd1);
    if (keep) expQ.push_back(d);
    @(posedge wrClk); #1;
    wrEn = 1'b0;
    @(negedge wrClk);
    while (wrDone) @(negedge wrClk);
    check("R1 done returns low", {31'd0, wrDone}, 32'd0);
    repeat (3) @(negedge busClk);
  endtask

  task automatic readWord();
    @(posedge busClk); #1;
    rdInc = 1'b1;
    @(posedge busClk); #1;
    rdInc = 1'b0;
  endtask

  // Monitor: every consumed word is compared with the scoreboard head
  always @(negedge busClk) begin
    if (rdInc && dataAvail) begin
      if (expQ.size() == 0) check({readTag, " unexpected word"}, rdData, 32'hxxxxxxxx);
      else check(readTag, rdData, expQ.pop_front());
    end
  end

  initial begin
    #(200000 * 4);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (4) @(negedge busClk);
    busRstN = 1; wrRstN = 1;
    // R11 reset state
    checkFlags("R11 reset flags", 5'b01000);
    check("R11 reset wrDone", {31'd0, wrDone}, 32'd0);
    check("R11 reset rxActive", {31'd0, rxActive}, 32'd0);

    // R1 / R10 single handshake
    writeWord(32'hA000_0001, 1, 1);
    check("R10 idle after write", {31'd0, rxActive}, 32'd0);
    checkFlags("R6 one word held", 5'b00010);
    check("R2 head visible", rdData, 32'hA000_0001);

    // R7 threshold
    for (int i = 2; i <= 7; i++) writeWord(32'hA000_0000 + i, 1, 0);
    checkFlags("R7 seven words", 5'b00010);
    writeWord(32'hA000_0008, 1, 0);
    checkFlags("R7 eight words", 5'b00110);

    // R2 / R3 drain in order
    readTag = "R3";
    for (int i = 0; i < 8; i++) readWord();
    checkFlags("R6 drained", 5'b01000);

    // R4 read while empty is ignored
    readWord();
    checkFlags("R4 still empty", 5'b01000);
    readTag = "R4";
    writeWord(32'hB000_00B0, 1, 0);
    readWord();
    checkFlags("R4 empty after one read", 5'b01000);

    // R5 / R8 fill across wrap, then overflow
    readTag = "R2";
    for (int i = 0; i < 16; i++) writeWord(32'hC000_0000 + i, 1, 0);
    checkFlags("R5 full", 5'b10110);
    writeWord(32'hDEAD_BEEF, 0, 0);
    checkFlags("R8 overrun set", 5'b10111);
    readTag = "R8";
    for (int i = 0; i < 16; i++) readWord();
    checkFlags("R8 sticky after drain", 5'b01001);
    @(posedge busClk); #1; ovrClear = 1;
    @(posedge busClk); #1; ovrClear = 0;
    checkFlags("R8 cleared", 5'b01000);

    // R9 disable
    for (int i = 0; i < 3; i++) writeWord(32'hE000_0000 + i, 0, 0);
    checkFlags("R9 three held", 5'b00010);
    @(posedge busClk); #1; fifoEnable = 0;
    repeat (2) @(negedge busClk);
    checkFlags("R9 flags low", 5'b00000);
    writeWord(32'hF000_000F, 0, 0);
    checkFlags("R9 write discarded", 5'b00000);
    @(posedge busClk); #1; fifoEnable = 1;
    checkFlags("R9 empty after enable", 5'b01000);
    readTag = "R9";
    writeWord(32'h1234_5678, 1, 0);
    check("R9 fresh head", rdData, 32'h1234_5678);
    readWord();
    checkFlags("R9 empty at end", 5'b01000);
    check("R2 scoreboard drained", expQ.size(), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule